// File: doc/BRIEF.md
# Halfband Interpolation Chain

This block raises the sample rate of a complex baseband stream (an I word and a Q word per sample) by a factor of 1, 2, 4 or 8. It is a cascade of identical 2x halfband interpolators. A head stage is always used in every interpolating mode. Behind it, a selectable section adds zero, one or two more 2x stages. In the 1x mode a single register bypasses all of the filters. Each 2x stage stuffs zeros and filters with a symmetric, linear-phase halfband kernel. Because the centre tap equals one half, every even output copies an input sample exactly. Every odd output is a rounded and saturated weighted sum of four neighbouring inputs.

The whole chain runs on one clock at the output rate. The caller presents one input sample every 2^m cycles, where m is the mode code, and drops `in_valid` between samples. While that cadence holds, the block produces exactly one output sample per clock. A change of `rate_sel` empties every delay line. The output then stays invalid until the pipeline of the new mode has refilled, so the first sample out afterwards is aligned to the first sample in.

Top module: `hb_interp_chain`

## Requirements
- R1: `rate_sel` selects the factor: 0 gives 1x, 1 gives 2x, 2 gives 4x, 3 gives 8x. A burst of N inputs after a flush yields N outputs in 1x mode. In the other modes, each active 2x stage turns K inputs into 2(K-2) outputs, so 12 inputs give 20, 36 and 68 outputs.
- R2: In 1x mode every accepted input appears unchanged on the outputs, with `out_valid` high, in the cycle after the edge that accepts it.
- R3: In each 2x stage, output 2j equals the stage's input sample j.
- R4: In each 2x stage, output 2j+1 equals floor((9*(x[j]+x[j+1]) - x[j+2] - x[j-1] + 8) / 16), where x[-1] is zero after a flush.
- R5: The odd-phase result is clamped to the range -32768 to 32767 instead of wrapping.
- R6: The I and Q words pass through identical filters and leave the block in the same cycle.
- R7: After reset or a flush, the filter history reads as zero. The first output sample is the first input sample accepted afterwards.
- R8: `out_valid` first rises at a fixed offset after the accepting edge. In 1x mode it rises 0 cycles after the first input. In 2x, 4x and 8x modes it rises 0, 5 and 14 cycles after the third input.
- R9: Once output has started, and while inputs arrive every 2^m cycles, exactly one output is produced per clock cycle with no gaps.
- R10: A change of `rate_sel` drops `out_valid` in the following cycle and clears all stage history.
- R11: While reset is held, `out_valid` is low and both output words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Interpolation factor code, log2 of the factor |
| in_valid | input | 1 | Input sample strobe, once per 2^rate_sel cycles |
| in_i | input | 16 | In-phase input word, two's complement |
| in_q | input | 16 | Quadrature input word, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | In-phase output word |
| out_q | output | 16 | Quadrature output word |

## Verification
Every stage registers its output, so a result appears in the cycle after the edge that produced it. The number of stages in a mode therefore fixes the start offset: 0 cycles for the bypass and the single stage, 5 cycles for two stages and 14 cycles for three, counted from the accepting edge named in R8. The bench drives its inputs just after the falling edge and samples at the falling edge. Each sample it takes is tagged with that edge's index, so the first output can be checked against the latency, and the contiguous run of outputs can be checked against the index of each output. The flush check samples `out_valid` exactly one edge after `rate_sel` changes.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    localparam int SAMPLE_W = 16;
    localparam int HB_INNER = 9;
    localparam int HB_OUTER = 1;
    localparam int HB_SHIFT = 4;
    localparam int HB_ROUND = 1 << (HB_SHIFT - 1);
    localparam int ACC_W    = SAMPLE_W + HB_SHIFT + 1;

    typedef logic signed [SAMPLE_W-1:0] word_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    typedef struct packed {
        word_t i;
        word_t q;
    } iq_t;

    // How many samples a stage holds since the last flush
    typedef enum logic [1:0] {
        FILL_NONE,
        FILL_ONE,
        FILL_PRIMED
    } fill_e;

    function automatic word_t sat_word(input acc_t v);
        acc_t hi;
        acc_t lo;
        word_t r;
        hi = acc_t'((1 << (SAMPLE_W - 1)) - 1);
        lo = ~hi;
        if (v > hi)
            r = word_t'(hi);
        else if (v < lo)
            r = word_t'(lo);
        else
            r = word_t'(v);
        return r;
    endfunction

endpackage

// File: rtl/hbi_odd_phase.sv
module hbi_odd_phase
    import hbi_pkg::*;
(
    input  word_t x_new,
    input  word_t x_mid_a,
    input  word_t x_mid_b,
    input  word_t x_old,
    output word_t y
);

    acc_t acc;
    acc_t scaled;

    // Odd polyphase branch of the halfband kernel: outer taps -1, inner taps 9, /16
    always_comb begin
        acc = (acc_t'(x_mid_a) + acc_t'(x_mid_b)) * acc_t'(HB_INNER)
            - (acc_t'(x_new) + acc_t'(x_old)) * acc_t'(HB_OUTER)
            + acc_t'(HB_ROUND);
        scaled = acc >>> HB_SHIFT;
        y = sat_word(scaled);
    end

endmodule

// File: rtl/hbi_stage.sv
module hbi_stage
    import hbi_pkg::*;
#(
    parameter int GAP_W = 2
)
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [GAP_W-1:0] gap,
    input  logic             in_valid,
    input  iq_t              in_s,
    output logic             out_valid,
    output iq_t              out_s
);

    localparam int TAPS = 3;

    iq_t              tap_q [TAPS];
    fill_e            fill_q;
    iq_t              pend_q;
    logic             pend_v;
    logic [GAP_W-1:0] cnt_q;
    iq_t              odd_c;

    hbi_odd_phase u_odd_i (
        .x_new   (in_s.i),
        .x_mid_a (tap_q[0].i),
        .x_mid_b (tap_q[1].i),
        .x_old   (tap_q[2].i),
        .y       (odd_c.i)
    );

    hbi_odd_phase u_odd_q (
        .x_new   (in_s.q),
        .x_mid_a (tap_q[0].q),
        .x_mid_b (tap_q[1].q),
        .x_old   (tap_q[2].q),
        .y       (odd_c.q)
    );

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int k = 0; k < TAPS; k++) tap_q[k] <= '0;
            fill_q    <= FILL_NONE;
            pend_q    <= '0;
            pend_v    <= 1'b0;
            cnt_q     <= '0;
            out_valid <= 1'b0;
            out_s     <= '0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                tap_q[0] <= in_s;
                for (int k = 1; k < TAPS; k++) tap_q[k] <= tap_q[k-1];
                if (fill_q == FILL_PRIMED) begin
                    out_s     <= tap_q[1];
                    out_valid <= 1'b1;
                    pend_q    <= odd_c;
                    pend_v    <= 1'b1;
                    cnt_q     <= gap;
                end else begin
                    fill_q <= (fill_q == FILL_NONE) ? FILL_ONE : FILL_PRIMED;
                end
            end else if (pend_v) begin
                if (cnt_q == '0) begin
                    out_s     <= pend_q;
                    out_valid <= 1'b1;
                    pend_v    <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    // R9
    pace_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> !pend_v)
        else $error("input arrived while the odd-phase sample was still pending");

    // R3
    even_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fill_q == FILL_PRIMED && !flush) |=> (out_valid && out_s == $past(tap_q[1])))
        else $error("even-phase output is not the held input sample");

endmodule

// File: rtl/hb_interp_chain.sv
module hb_interp_chain
    import hbi_pkg::*;
#(
    parameter int NSTAGE = 3
)
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [$clog2(NSTAGE+1)-1:0]   rate_sel,
    input  logic                          in_valid,
    input  logic signed [SAMPLE_W-1:0]    in_i,
    input  logic signed [SAMPLE_W-1:0]    in_q,
    output logic                          out_valid,
    output logic signed [SAMPLE_W-1:0]    out_i,
    output logic signed [SAMPLE_W-1:0]    out_q
);

    localparam int MW = $clog2(NSTAGE + 1);
    localparam int GW = (NSTAGE > 1) ? NSTAGE - 1 : 1;

    logic [MW-1:0]     rate_q;
    logic              flush;
    iq_t               in_s;
    iq_t               byp_s;
    logic              byp_v;
    iq_t               st_s [NSTAGE];
    logic [NSTAGE-1:0] st_v;
    logic [MW-1:0]     pick;

    assign flush  = (rate_sel != rate_q);
    assign in_s.i = in_i;
    assign in_s.q = in_q;

    always_ff @(posedge clk) begin
        rate_q <= rate_sel;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            byp_v <= 1'b0;
            byp_s <= '0;
        end else begin
            byp_v <= in_valid && (rate_q == '0);
            byp_s <= in_s;
        end
    end

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        logic          feed_v;
        iq_t           feed_s;
        logic [GW-1:0] gap;

        if (k == 0) begin : g_head
            assign feed_v = in_valid && (rate_q != '0);
            assign feed_s = in_s;
        end else begin : g_tail
            assign feed_v = st_v[k-1] && (int'(rate_q) > k);
            assign feed_s = st_s[k-1];
        end

        // Output spacing of this stage in the current mode, minus one
        always_comb begin
            if (int'(rate_q) > k)
                gap = GW'((1 << (int'(rate_q) - k - 1)) - 1);
            else
                gap = '0;
        end

        hbi_stage #(.GAP_W(GW)) u_stage (
            .clk       (clk),
            .rst       (rst),
            .flush     (flush),
            .gap       (gap),
            .in_valid  (feed_v),
            .in_s      (feed_s),
            .out_valid (st_v[k]),
            .out_s     (st_s[k])
        );
    end

    assign pick = rate_q - 1'b1;

    always_comb begin
        if (rate_q == '0) begin
            out_valid = byp_v;
            out_i     = byp_s.i;
            out_q     = byp_s.q;
        end else begin
            out_valid = st_v[pick];
            out_i     = st_s[pick].i;
            out_q     = st_s[pick].q;
        end
    end

    // R10
    flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !out_valid)
        else $error("output valid after a rate change");

    // R2
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!flush && rate_q == '0 && in_valid) |=>
            (out_valid && out_i == $past(in_i) && out_q == $past(in_q)))
        else $error("bypass did not pass the sample through");

endmodule

// File: tb/hb_interp_chain_tb_top.sv
`timescale 1ns/1ps
module hb_interp_chain_tb_top;

    localparam int NROW = 12;
    localparam int VI [NROW] = '{100, -32768, 32767, 32767, -32768, 1, 0, 2000, -1234, 7, 16000, -5};
    localparam int VQ [NROW] = '{-100, 32767, -32768, -32768, 32767, 0, 1, -3000, 4321, -7, -16000, 5};
    // per mode: code, expected output count, latency in cycles
    localparam int MODE_TAB [4][3] = '{'{0, 12, 0}, '{1, 20, 0}, '{2, 36, 5}, '{3, 68, 14}};

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [1:0]         rate_sel = 2'd0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic               out_valid;
    logic signed [15:0] out_i;
    logic signed [15:0] out_q;

    int obs_i [256];
    int obs_q [256];
    int obs_c [256];
    int acc_c [64];
    int nobs = 0;
    int nacc = 0;
    int nidx = 0;
    int ri [256];
    int rq [256];
    int nr = 0;
    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hb_interp_chain dut_i (
        .clk       (clk),
        .rst       (rst),
        .rate_sel  (rate_sel),
        .in_valid  (in_valid),
        .in_i      (in_i),
        .in_q      (in_q),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    always @(negedge clk) begin
        nidx++;
        if (in_valid && nacc < 64) begin
            acc_c[nacc] = nidx;
            nacc++;
        end
        if (out_valid && nobs < 256) begin
            obs_i[nobs] = out_i;
            obs_q[nobs] = out_q;
            obs_c[nobs] = nidx;
            nobs++;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int hb(input int a, input int b, input int c, input int d);
        int acc;
        acc = 9 * (b + c) - a - d + 8;
        acc = acc >>> 4;
        if (acc > 32767) acc = 32767;
        if (acc < -32768) acc = -32768;
        return acc;
    endfunction

    task automatic build_ref(input int m);
        int ti [256];
        int tq [256];
        int nt;
        nr = NROW;
        for (int k = 0; k < NROW; k++) begin
            ri[k] = VI[k];
            rq[k] = VQ[k];
        end
        for (int s = 0; s < m; s++) begin
            nt = 0;
            for (int j = 0; j + 2 < nr; j++) begin
                ti[nt] = ri[j];
                tq[nt] = rq[j];
                nt++;
                ti[nt] = hb(ri[j+2], ri[j+1], ri[j], (j > 0) ? ri[j-1] : 0);
                tq[nt] = hb(rq[j+2], rq[j+1], rq[j], (j > 0) ? rq[j-1] : 0);
                nt++;
            end
            nr = nt;
            for (int k = 0; k < nt; k++) begin
                ri[k] = ti[k];
                rq[k] = tq[k];
            end
        end
    endtask

    task automatic send(input int vi, input int vq, input int f);
        @(negedge clk); #1;
        in_valid = 1'b1;
        in_i = 16'(vi);
        in_q = 16'(vq);
        for (int k = 1; k < f; k++) begin
            @(negedge clk); #1;
            in_valid = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #1;
            in_valid = 1'b0;
        end
    endtask

    task automatic compare_run(input int m, input int lat, input string tagset);
        int bad_seq;
        int n;
        build_ref(m);
        check({"R1 output count ", tagset}, nobs, nr);
        n = (nobs < nr) ? nobs : nr;
        for (int k = 0; k < n; k++) begin
            if (m == 0)
                check("R2 bypass I", obs_i[k], ri[k]);
            else if (k % 2 == 0)
                check("R3 even phase I", obs_i[k], ri[k]);
            else
                check("R4 odd phase I", obs_i[k], ri[k]);
            check("R6 Q path", obs_q[k], rq[k]);
        end
        if (nobs > 0 && nacc > 2)
            check({"R8 first-output latency ", tagset}, obs_c[0] - acc_c[(m == 0) ? 0 : 2], lat);
        else
            check("R8 output present", nobs, nr);
        bad_seq = 0;
        for (int k = 1; k < n; k++)
            if (obs_c[k] != obs_c[0] + k) bad_seq++;
        check("R9 gaps in output run", bad_seq, 0);
    endtask

    task automatic run_mode(input int m, input int lat);
        @(negedge clk); #1;
        rst = 1'b1;
        rate_sel = 2'(m);
        idle(3);
        rst = 1'b0;
        nobs = 0;
        nacc = 0;
        for (int r = 0; r < NROW; r++) send(VI[r], VQ[r], 1 << m);
        idle(40);
        compare_run(m, lat, "mode run");
        if (m == 1) begin
            // R5: saturation at both rails, output 5 of the 2x run
            check("R5 clamp high I", obs_i[5], 32767);
            check("R5 clamp low Q", obs_q[5], -32768);
            check("R7 first output is first input", obs_i[0], 100);
        end
    endtask

    initial begin
        idle(3);
        // R11
        check("R11 reset out_valid", int'(out_valid), 0);
        check("R11 reset out_i", int'(out_i), 0);
        check("R11 reset out_q", int'(out_q), 0);

        for (int t = 0; t < 4; t++)
            run_mode(MODE_TAB[t][0], MODE_TAB[t][2]);

        // R10: switch 8x -> 2x mid-stream, history must be gone
        @(negedge clk); #1;
        rst = 1'b1;
        rate_sel = 2'd3;
        idle(3);
        rst = 1'b0;
        for (int r = 0; r < 6; r++) send(VI[NROW-1-r], VQ[NROW-1-r], 8);
        @(negedge clk); #1;
        rate_sel = 2'd1;
        nobs = 0;
        nacc = 0;
        @(negedge clk); #1;
        check("R10 out_valid low after rate change", int'(out_valid), 0);
        for (int r = 0; r < NROW; r++) send(VI[r], VQ[r], 2);
        idle(30);
        compare_run(1, 0, "after rate change R10");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL R9 watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule